// File: doc/BRIEF.md
# Dual-Width Shadowed Register File

This block is a general-purpose register store with two views of each entry. The narrow view holds a 32-bit scalar value. The wide view holds a 128-bit value. The two views are kept in separate storage and are updated together, so bits [31:0] of a wide entry always match the scalar entry at the same index. Scalar instructions read the narrow view. Packed and multi-word instructions read the wide view.

There are two combinational read ports. Each one returns both views of the register it addresses. Index 0 always reads as zero, and writes to it are dropped.

There are two write paths:
- The main write port has a mode bit. In scalar mode it stores its low 32 bits and zeroes the upper 96 bits of the wide entry. In wide mode it stores all 128 bits.
- The lane port writes a single 32-bit lane. A load that takes several beats uses it to fill a wide register one lane per beat.

There is no internal bypass: a write becomes visible on the read ports from the cycle after its clock edge.

Top module: `dwide_regfile`

## Requirements
- R1: A synchronous active-low reset clears every entry, so that after reset every index reads 0 on both views of both ports.
- R2: On each read port, the scalar output always equals bits [31:0] of the wide output.
- R3: Scalar write (wr_mode=0) of data D to index n sets the wide entry to {96'd0, D[31:0]}. Any upper bits that were there before are cleared.
- R4: Wide write (wr_mode=1) of data D to index n stores all 128 bits of D, and the scalar entry becomes D[31:0].
- R5: Reading index 0 returns 0 on both the scalar and the wide output of either port.
- R6: Writes to index 0 are ignored in every mode: scalar, wide and lane.
- R7: A lane write with ln_sel=k (0..3) replaces bits [32k+31:32k] of the wide entry and leaves the other lanes unchanged. When k=0, the scalar entry takes the new value as well.
- R8: A read of an index in the same cycle as a write to that index returns the old value. The new value appears from the next cycle.
- R9: When the main write and the lane write target the same index in the same cycle, the lane is applied on top of the main write's result.
- R10: The two read ports are independent. Each returns the entry at its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_addr | input | 5 | Read port A index |
| ra_scalar | output | 32 | Port A scalar view |
| ra_wide | output | 128 | Port A wide view |
| rb_addr | input | 5 | Read port B index |
| rb_scalar | output | 32 | Port B scalar view |
| rb_wide | output | 128 | Port B wide view |
| wr_en | input | 1 | Main write enable |
| wr_mode | input | 1 | 0 = scalar (zero-extend), 1 = wide |
| wr_addr | input | 5 | Main write index |
| wr_data | input | 128 | Main write data (low 32 bits used in scalar mode) |
| ln_en | input | 1 | Lane write enable |
| ln_addr | input | 5 | Lane write index |
| ln_sel | input | 2 | Lane number, lane k covers bits [32k+31:32k] |
| ln_data | input | 32 | Lane write data |

## Verification
The bench builds the block with its default parameters: 32 entries, a 32-bit scalar width and a 128-bit wide width, which gives four lanes. With these values it can reach index 0 and the top index 31, and it can drive every lane number, including lane 0, which is the lane that also updates the scalar view. A reference model applies the main write first and the lane write on top of it. The bench compares both views of both ports against that model every cycle, through directed cases and a long run of random scalar, wide and lane writes.

// File: rtl/dwrf_pkg.sv
// Package for the dual-width register file.
// Holds the encoding of the main write mode.
package dwrf_pkg;
    typedef enum logic {
        WM_SCALAR = 1'b0,
        WM_WIDE   = 1'b1
    } wmode_e;
endpackage

// File: rtl/dwrf_entry_merge.sv
// Works out the next wide value for one register entry.
// The main write is applied first: a scalar write zero-extends, a wide write
// stores everything. A lane write is then applied on top of that result.
// Assumes the hit inputs are already qualified by address and by the
// index-0 exclusion.
module dwrf_entry_merge
    import dwrf_pkg::*;
#(
    parameter int SW    = 32,
    parameter int WW    = 128,
    parameter int LANES = WW / SW,
    parameter int LSELW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             main_hit,
    input  logic             main_mode,
    input  logic [WW-1:0]    main_data,
    input  logic             lane_hit,
    input  logic [LSELW-1:0] lane_sel,
    input  logic [SW-1:0]    lane_data,
    input  logic [WW-1:0]    cur_wide,
    output logic [WW-1:0]    nxt_wide,
    output logic             upd
);
    // Combine the main write and the lane overlay into the next value.
    always_comb begin
        nxt_wide = cur_wide;
        if (main_hit) begin
            if (wmode_e'(main_mode) == WM_WIDE)
                nxt_wide = main_data;
            else
                nxt_wide = {{(WW-SW){1'b0}}, main_data[SW-1:0]};
        end
        for (int k = 0; k < LANES; k++) begin
            if (lane_hit && lane_sel == LSELW'(k))
                nxt_wide[k*SW +: SW] = lane_data;
        end
        upd = main_hit | lane_hit;
    end
endmodule

// File: rtl/dwrf_bank.sv
// Storage for the register entries. The scalar view and the wide view are
// held in separate flops. Both are loaded together from the merged next
// value, so the low bits of the two views stay in lockstep.
// Assumes upd[0] is never asserted by the parent.
module dwrf_bank #(
    parameter int NREGS = 32,
    parameter int SW    = 32,
    parameter int WW    = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd      [NREGS],
    input  logic [WW-1:0] nxt_wide [NREGS],
    output logic [SW-1:0] scl_q    [NREGS],
    output logic [WW-1:0] wide_q   [NREGS]
);
    for (genvar i = 0; i < NREGS; i++) begin : g_ent
        // Clear on reset, otherwise load both views on an update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wide_q[i] <= '0;
                scl_q[i]  <= '0;
            end else if (upd[i]) begin
                wide_q[i] <= nxt_wide[i];
                scl_q[i]  <= nxt_wide[i][SW-1:0];
            end
        end
    end
endmodule

// File: rtl/dwrf_read_port.sv
// One combinational read port. It returns both views of the addressed entry,
// and index 0 is forced to zero on both.
// Assumes the address is below NREGS.
module dwrf_read_port #(
    parameter int NREGS = 32,
    parameter int SW    = 32,
    parameter int WW    = 128,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] scl_q  [NREGS],
    input  logic [WW-1:0] wide_q [NREGS],
    output logic [SW-1:0] scl,
    output logic [WW-1:0] wide
);
    // Select the entry, with a zero guard on index 0.
    always_comb begin
        if (addr == '0) begin
            scl  = '0;
            wide = '0;
        end else begin
            scl  = scl_q[addr];
            wide = wide_q[addr];
        end
    end
endmodule

// File: rtl/dwide_regfile.sv
// Register file with a 32-bit scalar view and a 128-bit wide view per entry.
// It has two read ports, a main write port with a scalar/wide mode, and a
// lane write port for multi-beat fills. Reads are combinational and have no
// bypass. Index 0 is hardwired to zero.
module dwide_regfile #(
    parameter int NREGS = 32,
    parameter int SW    = 32,
    parameter int WW    = 128,
    parameter int AW    = $clog2(NREGS),
    parameter int LANES = WW / SW,
    parameter int LSELW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra_addr,
    output logic [SW-1:0]    ra_scalar,
    output logic [WW-1:0]    ra_wide,
    input  logic [AW-1:0]    rb_addr,
    output logic [SW-1:0]    rb_scalar,
    output logic [WW-1:0]    rb_wide,
    input  logic             wr_en,
    input  logic             wr_mode,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WW-1:0]    wr_data,
    input  logic             ln_en,
    input  logic [AW-1:0]    ln_addr,
    input  logic [LSELW-1:0] ln_sel,
    input  logic [SW-1:0]    ln_data
);
    logic          upd      [NREGS];
    logic [WW-1:0] nxt_wide [NREGS];
    logic [SW-1:0] scl_q    [NREGS];
    logic [WW-1:0] wide_q   [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_wr
        if (i == 0) begin : g_zero
            // Index 0 never takes a write.
            assign upd[i]      = 1'b0;
            assign nxt_wide[i] = '0;
        end else begin : g_live
            logic main_hit;
            logic lane_hit;
            // Decode whether each write path targets this entry.
            assign main_hit = wr_en && (wr_addr == AW'(i));
            assign lane_hit = ln_en && (ln_addr == AW'(i));

            dwrf_entry_merge #(
                .SW(SW), .WW(WW), .LANES(LANES), .LSELW(LSELW)
            ) i_merge (
                .main_hit (main_hit),
                .main_mode(wr_mode),
                .main_data(wr_data),
                .lane_hit (lane_hit),
                .lane_sel (ln_sel),
                .lane_data(ln_data),
                .cur_wide (wide_q[i]),
                .nxt_wide (nxt_wide[i]),
                .upd      (upd[i])
            );
        end
    end

    dwrf_bank #(.NREGS(NREGS), .SW(SW), .WW(WW)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .nxt_wide(nxt_wide),
        .scl_q   (scl_q),
        .wide_q  (wide_q)
    );

    dwrf_read_port #(.NREGS(NREGS), .SW(SW), .WW(WW), .AW(AW)) i_rda (
        .addr  (ra_addr),
        .scl_q (scl_q),
        .wide_q(wide_q),
        .scl   (ra_scalar),
        .wide  (ra_wide)
    );

    dwrf_read_port #(.NREGS(NREGS), .SW(SW), .WW(WW), .AW(AW)) i_rdb (
        .addr  (rb_addr),
        .scl_q (scl_q),
        .wide_q(wide_q),
        .scl   (rb_scalar),
        .wide  (rb_wide)
    );
endmodule

// File: rtl/dwrf_checker.sv
// Property checker for dwide_regfile, attached with a bind statement.
// It only observes the ports of the top module.
module dwrf_checker #(
    parameter int NREGS = 32,
    parameter int SW    = 32,
    parameter int WW    = 128,
    parameter int AW    = $clog2(NREGS),
    parameter int LANES = WW / SW,
    parameter int LSELW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    ra_addr,
    input logic [SW-1:0]    ra_scalar,
    input logic [WW-1:0]    ra_wide,
    input logic [AW-1:0]    rb_addr,
    input logic [SW-1:0]    rb_scalar,
    input logic [WW-1:0]    rb_wide,
    input logic             wr_en,
    input logic             wr_mode,
    input logic [AW-1:0]    wr_addr,
    input logic [WW-1:0]    wr_data,
    input logic             ln_en,
    input logic [AW-1:0]    ln_addr,
    input logic [LSELW-1:0] ln_sel,
    input logic [SW-1:0]    ln_data
);
    // Pick one lane out of a wide value.
    function automatic logic [SW-1:0] lane_of(input logic [WW-1:0] w, input logic [LSELW-1:0] s);
        logic [SW-1:0] r;
        r = '0;
        for (int k = 0; k < LANES; k++)
            if (s == LSELW'(k)) r = w[k*SW +: SW];
        return r;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ra_wide == '0 && rb_wide == '0)); // R1

    AST_LOW_AGREE_A: assert property (@(posedge clk) disable iff (!rst_n)
        ra_scalar == ra_wide[SW-1:0]); // R2

    AST_LOW_AGREE_B: assert property (@(posedge clk) disable iff (!rst_n)
        rb_scalar == rb_wide[SW-1:0]); // R2

    AST_SCALAR_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_mode && wr_addr != '0 && !(ln_en && ln_addr == wr_addr))
        |=> (ra_addr != $past(wr_addr) || ra_wide[WW-1:SW] == '0)); // R3

    AST_WIDE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode && wr_addr != '0 && !(ln_en && ln_addr == wr_addr))
        |=> (ra_addr != $past(wr_addr) || ra_wide == $past(wr_data))); // R4

    AST_ZERO_INDEX_A: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == '0) |-> (ra_wide == '0 && ra_scalar == '0)); // R5

    AST_ZERO_INDEX_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_addr == '0) |-> (rb_wide == '0 && rb_scalar == '0)); // R5

    AST_LANE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_en && ln_addr != '0)
        |=> (ra_addr != $past(ln_addr) || lane_of(ra_wide, $past(ln_sel)) == $past(ln_data))); // R7
endmodule

bind dwide_regfile dwrf_checker #(
    .NREGS(NREGS), .SW(SW), .WW(WW), .AW(AW), .LANES(LANES), .LSELW(LSELW)
) i_dwrf_checker (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .ra_scalar(ra_scalar), .ra_wide(ra_wide),
    .rb_addr(rb_addr), .rb_scalar(rb_scalar), .rb_wide(rb_wide),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .ln_en(ln_en), .ln_addr(ln_addr), .ln_sel(ln_sel), .ln_data(ln_data)
);

// File: tb/test_dwide_regfile.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected read values from a reference
// model, and the monitor pops them and compares against both ports.
module test_dwide_regfile;
    localparam int NREGS = 32;
    localparam int SW    = 32;
    localparam int WW    = 128;
    localparam int AW    = 5;
    localparam int LSELW = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    ra_addr = '0, rb_addr = '0;
    logic [SW-1:0]    ra_scalar, rb_scalar;
    logic [WW-1:0]    ra_wide, rb_wide;
    logic             wr_en = 1'b0, wr_mode = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WW-1:0]    wr_data = '0;
    logic             ln_en = 1'b0;
    logic [AW-1:0]    ln_addr = '0;
    logic [LSELW-1:0] ln_sel = '0;
    logic [SW-1:0]    ln_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [WW-1:0] mdl [NREGS];

    typedef struct {
        bit            port_b;
        logic [AW-1:0] addr;
        logic [WW-1:0] exp;
        string         tag;
    } item_t;
    item_t sb_q[$];
    item_t it;

    always #5 clk = ~clk;

    dwide_regfile i_dwide_regfile (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(ra_addr), .ra_scalar(ra_scalar), .ra_wide(ra_wide),
        .rb_addr(rb_addr), .rb_scalar(rb_scalar), .rb_wide(rb_wide),
        .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
        .ln_en(ln_en), .ln_addr(ln_addr), .ln_sel(ln_sel), .ln_data(ln_data)
    );

    // Monitor: compare both views of each queued read, just after each falling edge.
    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            logic [WW-1:0] gw;
            logic [SW-1:0] gs;
            it = sb_q.pop_front();
            gw = it.port_b ? rb_wide : ra_wide;
            gs = it.port_b ? rb_scalar : ra_scalar;
            checks++;
            if (gw !== it.exp) begin
                errors++;
                $display("FAIL %s wide port%s idx %0d: got %h exp %h",
                         it.tag, it.port_b ? "B" : "A", it.addr, gw, it.exp);
            end
            checks++;
            if (gs !== it.exp[SW-1:0]) begin
                errors++;
                $display("FAIL %s/R2 scalar port%s idx %0d: got %h exp %h",
                         it.tag, it.port_b ? "B" : "A", it.addr, gs, it.exp[SW-1:0]);
            end
        end
    end

    // Driver: one cycle of stimulus. It queues the old values for both read
    // addresses, then applies the write rules to the model.
    task automatic step(input bit we, input bit mode, input logic [AW-1:0] wa,
                        input logic [WW-1:0] wd, input bit le, input logic [AW-1:0] la,
                        input logic [LSELW-1:0] ls, input logic [SW-1:0] ld,
                        input logic [AW-1:0] a, input logic [AW-1:0] b, input string tag);
        item_t x;
        @(negedge clk);
        wr_en = we; wr_mode = mode; wr_addr = wa; wr_data = wd;
        ln_en = le; ln_addr = la; ln_sel = ls; ln_data = ld;
        ra_addr = a; rb_addr = b;
        x.port_b = 0; x.addr = a; x.exp = mdl[a]; x.tag = tag; sb_q.push_back(x);
        x.port_b = 1; x.addr = b; x.exp = mdl[b]; x.tag = tag; sb_q.push_back(x);
        if (we && wa != 0)
            mdl[wa] = mode ? wd : {96'd0, wd[SW-1:0]};
        if (le && la != 0)
            mdl[la][ls*SW +: SW] = ld;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [AW-1:0] b, input string tag);
        step(0, 0, 0, '0, 0, 0, 0, '0, a, b, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0; ln_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < NREGS; i++) mdl[i] = '0;
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREGS; i++) mdl[i] = '0;
        do_reset();
        // R1: every index reads zero after reset; R10 through distinct port addresses
        for (int i = 0; i < NREGS; i += 2) rd(AW'(i), AW'(i+1), "R1/R10");

        // R3: a scalar write drops the upper data bits
        step(1, 0, 5, 128'hDEAD_BEEF_1111_2222_3333_4444_5566_7788, 0, 0, 0, '0, 0, 0, "R3");
        rd(5, 31, "R3");
        // R4: a wide write keeps all 128 bits
        step(1, 1, 6, 128'hA5A5_0001_B6B6_0002_C7C7_0003_D8D8_0004, 0, 0, 0, '0, 6, 5, "R8");
        rd(6, 5, "R4/R10");
        // R3: a scalar write clears the upper bits left by the earlier wide write
        step(1, 0, 6, 128'h0, 0, 0, 0, '0, 6, 0, "R8");
        step(1, 0, 6, {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h1234_5678}, 0, 0, 0, '0, 6, 6, "R3");
        rd(6, 6, "R3");

        // R6: writes to index 0 in every mode leave it reading zero (R5)
        step(1, 1, 0, {WW{1'b1}}, 1, 0, 2, 32'hFFFF_FFFF, 0, 0, "R6");
        step(1, 0, 0, {WW{1'b1}}, 1, 0, 0, 32'hFFFF_FFFF, 0, 0, "R6");
        rd(0, 0, "R5/R6");

        // R7: lane fills; lane 2 leaves the scalar alone, lane 0 updates it
        step(1, 1, 7, 128'h4444_4444_3333_3333_2222_2222_1111_1111, 0, 0, 0, '0, 0, 0, "R4");
        step(0, 0, 0, '0, 1, 7, 2, 32'hCAFE_F00D, 7, 0, "R7");
        rd(7, 7, "R7");
        step(0, 0, 0, '0, 1, 7, 0, 32'h0BAD_C0DE, 7, 0, "R7");
        rd(7, 7, "R7");
        step(0, 0, 0, '0, 1, 7, 3, 32'h7777_0000, 0, 0, "R7");
        step(0, 0, 0, '0, 1, 7, 1, 32'h5555_AAAA, 7, 7, "R7");
        rd(7, 0, "R7");

        // R8: a same-cycle read returns the old value, and the new one follows
        step(1, 1, 9, 128'h9999_8888_7777_6666_5555_4444_3333_2222, 0, 0, 0, '0, 9, 9, "R8");
        rd(9, 9, "R8");

        // R9: the lane write lands on top of a same-index main write
        step(1, 1, 10, 128'h1010_1010_2020_2020_3030_3030_4040_4040, 1, 10, 1, 32'hABCD_EF01, 0, 0, "R9");
        rd(10, 10, "R9");
        step(1, 0, 10, 128'hFFFF_0000_FFFF_0000_FFFF_0000_5A5A_5A5A, 1, 10, 3, 32'h3C3C_3C3C, 10, 0, "R9");
        rd(10, 10, "R9");
        step(1, 1, 11, 128'h0, 1, 11, 0, 32'h0F0F_F0F0, 0, 0, "R9");
        rd(11, 11, "R9");

        // R2: random mixed scalar, wide and lane writes against the model
        for (int n = 0; n < 400; n++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, AW'($urandom),
                 {$urandom, $urandom, $urandom, $urandom},
                 $urandom_range(0, 1) == 1, AW'($urandom), LSELW'($urandom), $urandom,
                 AW'($urandom), AW'($urandom), "R2");
        end

        // R1: reset after the register file is populated
        do_reset();
        for (int i = 0; i < NREGS; i += 2) rd(AW'(i+1), AW'(i), "R1");
        rd(0, 0, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule